// File: doc/BRIEF.md
# SIMD Vector-by-Scalar Integer Multiplier

This block takes the fields of a vector-by-scalar integer multiply and returns the decoded register numbers together with the product vector. One lane of a 64-bit scalar-source register is selected. That lane multiplies every lane of a 64-bit or 128-bit source vector, and each product is cut down to the lane width. Lanes are 16 or 32 bits wide. The block also decodes how the scalar register number and its lane index are packed for each lane width, and it reports encodings that are reserved, that belong to another operation, or that ask for floating point.

Requests arrive on a valid/ready stream and results leave on another. A request is taken on a clock edge when `in_valid` and `in_ready` are both high. Its result appears on the output one cycle later, with `out_valid` high. While `out_valid` is high and `out_ready` is low, the output holds its value and `in_ready` stays low. The block can therefore stall a producer but never drops a result. Reading the register file and evaluating conditions are left to the surrounding pipeline.

Top module: `sxm_vec_scalar_mul`

## Requirements
- R1: With size 01 (16-bit lanes), each result lane i is the low 16 bits of source lane i times scalar lane {m, vm[3]}. The scalar register number is {0, vm[2:0]} and the lane output is {m, vm[3]}.
- R2: With size 10 (32-bit lanes), each result lane i is the low 32 bits of source lane i times scalar lane m. The scalar register number is vm and the lane output is {0, m}.
- R3: The destination number is {d, vd} and the first source number is {n, vn}, each 5 bits wide, for every encoding.
- R4: When q=1, all 128 bits of the source are multiplied by the same scalar lane. When q=0, result bits 127:64 are zero.
- R5: Size 11 raises `out_other_enc` only, and the result is zero.
- R6: Size 00 raises `out_undef` only, and the result is zero.
- R7: When q=1 and either vd[0] or vn[0] is 1, `out_undef` is raised only, and the result is zero.
- R8: When f=1, with size 01 or 10 and no other fault, `out_unsup` is raised only, and the result is zero.
- R9: An accepted request gives `out_valid` on the next cycle. `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. A stalled output holds its value.
- R10: While reset is applied, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be taken |
| in_q | input | 1 | 128-bit operation when 1 |
| in_f | input | 1 | Floating-point request |
| in_size | input | 2 | Lane size code |
| in_d | input | 1 | Destination number high bit |
| in_vd | input | 4 | Destination number low bits |
| in_n | input | 1 | Source number high bit |
| in_vn | input | 4 | Source number low bits |
| in_m | input | 1 | Scalar lane / register field bit |
| in_vm | input | 4 | Scalar register field |
| in_vec | input | 128 | Source vector |
| in_scalar_reg | input | 64 | Register holding the scalar |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes result |
| out_dst | output | 5 | Destination register number |
| out_src | output | 5 | First source register number |
| out_scl_reg | output | 4 | Scalar register number |
| out_lane | output | 2 | Scalar lane index |
| out_undef | output | 1 | Undefined encoding |
| out_other_enc | output | 1 | Encoding of another operation |
| out_unsup | output | 1 | Floating point, not handled |
| out_result | output | 128 | Product vector |

## Verification
The hardest case to reach from the ports is a stall with a second request waiting. Here the held result must not change while the next request sits on the input. To create it, the bench holds `out_ready` low for one cycle after a result appears and presents a second request with different operands in that same cycle. It then checks that `in_ready` is low and that the first result has not changed. Finally it releases `out_ready` and checks that the second result follows. The odd-register faults only matter when q=1, so the table includes 128-bit entries with an odd destination number and entries with an odd source number.

// File: rtl/sxm_pkg.sv
package sxm_pkg;
  typedef enum logic [1:0] {
    SZ_RSV  = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_ALT  = 2'b11
  } size_code_e;

  typedef struct packed {
    logic [4:0] dst;
    logic [4:0] src;
    logic [3:0] scl_reg;
    logic [1:0] lane;
    logic       is_word;
    logic       undef;
    logic       other;
    logic       unsup;
  } dec_t;

  localparam int HALF_W = 16;
  localparam int WORD_W = 32;
endpackage

// File: rtl/sxm_decode.sv
module sxm_decode
  import sxm_pkg::*;
(
  input  logic       q,
  input  logic       f,
  input  logic [1:0] size,
  input  logic       d,
  input  logic [3:0] vd,
  input  logic       n,
  input  logic [3:0] vn,
  input  logic       m,
  input  logic [3:0] vm,
  output dec_t       dec
);
  logic odd_pair;

  always_comb begin
    odd_pair      = q && (vd[0] || vn[0]);
    dec.dst       = {d, vd};
    dec.src       = {n, vn};
    dec.is_word   = (size == SZ_WORD);
    dec.scl_reg   = dec.is_word ? vm : {1'b0, vm[2:0]};
    dec.lane      = dec.is_word ? {1'b0, m} : {m, vm[3]};
    dec.other     = (size == SZ_ALT);
    dec.undef     = !dec.other && ((size == SZ_RSV) || odd_pair);
    dec.unsup     = !dec.other && !dec.undef && f;
  end
endmodule

// File: rtl/sxm_scalar_pick.sv
module sxm_scalar_pick
  import sxm_pkg::*;
#(
  parameter int REG_W = 64
) (
  input  logic [REG_W-1:0]  scalar_reg,
  input  logic              is_word,
  input  logic [1:0]        lane,
  output logic [WORD_W-1:0] scalar
);
  localparam int H_LANES = REG_W / HALF_W;
  localparam int W_LANES = REG_W / WORD_W;

  logic [HALF_W-1:0] half_lanes [H_LANES];
  logic [WORD_W-1:0] word_lanes [W_LANES];

  for (genvar h = 0; h < H_LANES; h++) begin : g_half
    assign half_lanes[h] = scalar_reg[h*HALF_W +: HALF_W];
  end
  for (genvar w = 0; w < W_LANES; w++) begin : g_word
    assign word_lanes[w] = scalar_reg[w*WORD_W +: WORD_W];
  end

  always_comb begin
    if (is_word) scalar = word_lanes[lane[0]];
    else         scalar = {{(WORD_W-HALF_W){1'b0}}, half_lanes[lane]};
  end
endmodule

// File: rtl/sxm_lane_mul.sv
module sxm_lane_mul #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p
);
  assign p = a * b;
endmodule

// File: rtl/sxm_lane_array.sv
module sxm_lane_array
  import sxm_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0]  vec,
  input  logic [WORD_W-1:0] scalar,
  input  logic              is_word,
  output logic [VEC_W-1:0]  prod
);
  localparam int NH = VEC_W / HALF_W;
  localparam int NW = VEC_W / WORD_W;

  logic [VEC_W-1:0] prod_h;
  logic [VEC_W-1:0] prod_w;

  for (genvar i = 0; i < NH; i++) begin : g_h
    sxm_lane_mul #(.W(HALF_W)) u_mul (
      .a(vec[i*HALF_W +: HALF_W]),
      .b(scalar[HALF_W-1:0]),
      .p(prod_h[i*HALF_W +: HALF_W])
    );
  end
  for (genvar j = 0; j < NW; j++) begin : g_w
    sxm_lane_mul #(.W(WORD_W)) u_mul (
      .a(vec[j*WORD_W +: WORD_W]),
      .b(scalar),
      .p(prod_w[j*WORD_W +: WORD_W])
    );
  end

  assign prod = is_word ? prod_w : prod_h;
endmodule

// File: rtl/sxm_vec_scalar_mul.sv
module sxm_vec_scalar_mul
  import sxm_pkg::*;
#(
  parameter int REG_W = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_q,
  input  logic                 in_f,
  input  logic [1:0]           in_size,
  input  logic                 in_d,
  input  logic [3:0]           in_vd,
  input  logic                 in_n,
  input  logic [3:0]           in_vn,
  input  logic                 in_m,
  input  logic [3:0]           in_vm,
  input  logic [2*REG_W-1:0]   in_vec,
  input  logic [REG_W-1:0]     in_scalar_reg,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [4:0]           out_dst,
  output logic [4:0]           out_src,
  output logic [3:0]           out_scl_reg,
  output logic [1:0]           out_lane,
  output logic                 out_undef,
  output logic                 out_other_enc,
  output logic                 out_unsup,
  output logic [2*REG_W-1:0]   out_result
);
  localparam int VEC_W = 2 * REG_W;

  dec_t              dec;
  logic [WORD_W-1:0] scalar;
  logic [VEC_W-1:0]  prod;
  logic [VEC_W-1:0]  result_c;
  logic              fault;
  logic              take;
  logic              q_r;

  sxm_decode u_dec (
    .q(in_q), .f(in_f), .size(in_size), .d(in_d), .vd(in_vd),
    .n(in_n), .vn(in_vn), .m(in_m), .vm(in_vm), .dec(dec)
  );

  sxm_scalar_pick #(.REG_W(REG_W)) u_pick (
    .scalar_reg(in_scalar_reg), .is_word(dec.is_word),
    .lane(dec.lane), .scalar(scalar)
  );

  sxm_lane_array #(.VEC_W(VEC_W)) u_arr (
    .vec(in_vec), .scalar(scalar), .is_word(dec.is_word), .prod(prod)
  );

  always_comb begin
    fault = dec.undef || dec.other || dec.unsup;
    if (fault)      result_c = '0;
    else if (in_q)  result_c = prod;
    else            result_c = {{REG_W{1'b0}}, prod[REG_W-1:0]};
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_dst       <= '0;
      out_src       <= '0;
      out_scl_reg   <= '0;
      out_lane      <= '0;
      out_undef     <= 1'b0;
      out_other_enc <= 1'b0;
      out_unsup     <= 1'b0;
      out_result    <= '0;
      q_r           <= 1'b0;
    end else if (take) begin
      out_dst       <= dec.dst;
      out_src       <= dec.src;
      out_scl_reg   <= dec.scl_reg;
      out_lane      <= dec.lane;
      out_undef     <= dec.undef;
      out_other_enc <= dec.other;
      out_unsup     <= dec.unsup;
      out_result    <= result_c;
      q_r           <= in_q;
    end
  end
endmodule

// File: rtl/sxm_checker.sv
module sxm_checker #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             q_r,
  input logic [4:0]       out_dst,
  input logic [4:0]       out_src,
  input logic             out_undef,
  input logic             out_other_enc,
  input logic             out_unsup,
  input logic [VEC_W-1:0] out_result
);
  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_dst)); // R9
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_undef || out_other_enc || out_unsup) |-> out_result == '0); // R5
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_undef, out_other_enc, out_unsup})); // R8
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !q_r |-> out_result[VEC_W-1:VEC_W/2] == '0); // R4
  AST_ODD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && q_r && (out_dst[0] || out_src[0]) && !out_other_enc |-> out_undef); // R7
endmodule

bind sxm_vec_scalar_mul sxm_checker #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .q_r(q_r),
  .out_dst(out_dst), .out_src(out_src), .out_undef(out_undef),
  .out_other_enc(out_other_enc), .out_unsup(out_unsup), .out_result(out_result)
);

// File: tb/tb_sxm_vec_scalar_mul.sv
`timescale 1ns/1ps
module tb_sxm_vec_scalar_mul;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_ready;
  logic         in_q = 1'b0, in_f = 1'b0, in_d = 1'b0, in_n = 1'b0, in_m = 1'b0;
  logic [1:0]   in_size = 2'b01;
  logic [3:0]   in_vd = '0, in_vn = '0, in_vm = '0;
  logic [127:0] in_vec = '0;
  logic [63:0]  in_scalar_reg = '0;
  logic         out_valid, out_ready = 1'b1;
  logic [4:0]   out_dst, out_src;
  logic [3:0]   out_scl_reg;
  logic [1:0]   out_lane;
  logic         out_undef, out_other_enc, out_unsup;
  logic [127:0] out_result;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sxm_vec_scalar_mul dut (.*);

  // fields: {q, f, size, d, vd, n, vn, m, vm}
  localparam logic [18:0] TBL [0:17] = '{
    {1'b0,1'b0,2'b01,1'b0,4'd3, 1'b1,4'd5, 1'b0,4'b0010},
    {1'b0,1'b0,2'b01,1'b1,4'd7, 1'b0,4'd1, 1'b0,4'b1011},
    {1'b0,1'b0,2'b01,1'b0,4'd0, 1'b1,4'd15,1'b1,4'b0100},
    {1'b0,1'b0,2'b01,1'b1,4'd15,1'b0,4'd9, 1'b1,4'b1111},
    {1'b1,1'b0,2'b01,1'b0,4'd2, 1'b0,4'd6, 1'b0,4'b0001},
    {1'b1,1'b0,2'b01,1'b1,4'd4, 1'b1,4'd8, 1'b0,4'b1110},
    {1'b1,1'b0,2'b01,1'b0,4'd10,1'b1,4'd12,1'b1,4'b0011},
    {1'b1,1'b0,2'b01,1'b1,4'd14,1'b0,4'd0, 1'b1,4'b1101},
    {1'b0,1'b0,2'b10,1'b0,4'd1, 1'b0,4'd2, 1'b0,4'd9},
    {1'b0,1'b0,2'b10,1'b1,4'd11,1'b1,4'd3, 1'b1,4'd14},
    {1'b1,1'b0,2'b10,1'b0,4'd8, 1'b0,4'd0, 1'b0,4'd5},
    {1'b1,1'b0,2'b10,1'b1,4'd6, 1'b1,4'd10,1'b1,4'd15},
    {1'b0,1'b0,2'b00,1'b0,4'd2, 1'b0,4'd4, 1'b0,4'd1},
    {1'b1,1'b0,2'b11,1'b0,4'd2, 1'b0,4'd4, 1'b1,4'd3},
    {1'b1,1'b0,2'b01,1'b0,4'd3, 1'b0,4'd4, 1'b0,4'd1},
    {1'b1,1'b0,2'b10,1'b0,4'd4, 1'b0,4'd7, 1'b1,4'd2},
    {1'b0,1'b1,2'b01,1'b1,4'd6, 1'b0,4'd2, 1'b1,4'd8},
    {1'b1,1'b1,2'b10,1'b0,4'd2, 1'b0,4'd4, 1'b0,4'd11}
  };

  task automatic chk(input logic ok, input string req,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] ref_mul(input logic q, input logic [1:0] sz,
      input logic m, input logic [3:0] vm, input logic [127:0] v, input logic [63:0] s);
    logic [127:0] r = '0;
    logic [15:0] sh;
    logic [31:0] sw;
    if (sz == 2'b01) begin
      sh = s[int'({m, vm[3]})*16 +: 16];
      for (int i = 0; i < 8; i++) r[i*16 +: 16] = v[i*16 +: 16] * sh;
    end else begin
      sw = s[int'(m)*32 +: 32];
      for (int i = 0; i < 4; i++) r[i*32 +: 32] = v[i*32 +: 32] * sw;
    end
    if (!q) r[127:64] = '0;
    return r;
  endfunction

  task automatic drive(input logic [18:0] e, input logic [127:0] v, input logic [63:0] s);
    {in_q, in_f, in_size, in_d, in_vd, in_n, in_vn, in_m, in_vm} = e;
    in_vec = v;
    in_scalar_reg = s;
  endtask

  task automatic run_entry(input logic [18:0] e);
    logic q, f, d, n, m, other, undef, unsup, word;
    logic [1:0] sz;
    logic [3:0] vd, vn, vm;
    logic [127:0] v, exp;
    logic [63:0] s;
    string rq;
    {q, f, sz, d, vd, n, vn, m, vm} = e;
    v = {$urandom, $urandom, $urandom, $urandom};
    s = {$urandom, $urandom};
    other = (sz == 2'b11);
    undef = !other && (sz == 2'b00 || (q && (vd[0] || vn[0])));
    unsup = !other && !undef && f;
    word  = (sz == 2'b10);
    exp   = (other || undef || unsup) ? '0 : ref_mul(q, sz, m, vm, v, s);
    @(negedge clk);
    drive(e, v, s);
    in_valid = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R9", 128'(out_valid), 128'(1));
    chk(out_dst == {d, vd} && out_src == {n, vn}, "R3",
        128'({out_dst, out_src}), 128'({d, vd, n, vn}));
    chk(out_other_enc == other, "R5", 128'(out_other_enc), 128'(other));
    if (other) rq = "R5";
    else if (sz == 2'b00) rq = "R6";
    else if (undef) rq = "R7";
    else if (unsup) rq = "R8";
    else rq = word ? "R2" : "R1";
    chk(out_undef == undef, rq, 128'(out_undef), 128'(undef));
    chk(out_unsup == unsup, "R8", 128'(out_unsup), 128'(unsup));
    chk(out_result == exp, rq, out_result, exp);
    if (!(other || undef || unsup)) begin
      chk(out_scl_reg == (word ? vm : {1'b0, vm[2:0]}) &&
          out_lane == (word ? {1'b0, m} : {m, vm[3]}), rq,
          128'({out_scl_reg, out_lane}), 128'(word ? {vm, 1'b0, m} : {1'b0, vm[2:0], m, vm[3]}));
      chk(out_result[127:64] == exp[127:64], "R4", out_result, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] va, vb, ea, eb;
    logic [63:0] sa, sb;
    logic [18:0] ea_e, eb_e;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R10", 128'(out_valid), 128'(0));
    chk(in_ready == 1'b1, "R10", 128'(in_ready), 128'(1));
    rst_n = 1'b1;
    for (int pass = 0; pass < 2; pass++)
      for (int k = 0; k < 18; k++) run_entry(TBL[k]);

    // stall with a second request waiting: R9
    ea_e = TBL[5];
    eb_e = TBL[11];
    va = {$urandom, $urandom, $urandom, $urandom};
    vb = {$urandom, $urandom, $urandom, $urandom};
    sa = {$urandom, $urandom};
    sb = {$urandom, $urandom};
    ea = ref_mul(1'b1, 2'b01, 1'b0, 4'b1110, va, sa);
    eb = ref_mul(1'b1, 2'b10, 1'b1, 4'd15, vb, sb);
    @(negedge clk);
    drive(ea_e, va, sa);
    in_valid = 1'b1;
    out_ready = 1'b0;
    @(negedge clk);
    drive(eb_e, vb, sb);
    chk(in_ready == 1'b0, "R9", 128'(in_ready), 128'(0));
    chk(out_result == ea, "R9", out_result, ea);
    @(negedge clk);
    chk(out_valid == 1'b1 && out_result == ea, "R9", out_result, ea);
    chk(in_ready == 1'b0, "R9", 128'(in_ready), 128'(0));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1 && out_result == eb, "R9", out_result, eb);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", 128'(out_valid), 128'(0));

    // reset during activity: R10
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R10",
        128'({out_valid, in_ready}), 128'(2'b01));
    rst_n = 1'b1;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule